// File: doc/BRIEF.md
# Multiplierless Fixed-Coefficient FIR Filter

This block filters a stream of signed samples with a four-tap direct-form FIR. The coefficients are fixed when the design is elaborated. No multiplier is built. Each weight is made from up to three arithmetically right-shifted copies of a sample, and each copy can be added or subtracted. The shifts are wiring, so the only logic is the adders.

A sample enters when `in_valid` is high. A three-register delay line keeps the three previous accepted samples. The current sample and the three delayed samples are each weighted by their shift-add unit. A pairwise adder tree then forms the full-width result in an output register. The parameter `PIPE` can add one register stage in the middle of the adder tree. This splits the long path from the sample input through the weights to the output register, and it costs one cycle of latency.

Top module: `fir_shiftadd`

## Requirements
- R1: When `in_valid` is high, the value that later appears on `out_y` is w0(x(n)) + w1(x(n-1)) + w2(x(n-2)) + w3(x(n-3)). Here x(n) is `in_data` in that cycle, x(n-k) is the k-th previously accepted sample, and wk is the weight function of tap k.
- R2: The delay line advances only on an accepted sample. x(n-1) becomes the sample just accepted, and the older samples move one place down.
- R3: A cycle with `in_valid` low has no effect on the delay line. `out_y` holds its last value, and `out_valid` is low `1+PIPE` cycles later.
- R4: Each weight term sign-extends the sample to DW+3 bits and shifts it right arithmetically by 1 to 15 places, rounding toward minus infinity. The term is then added or subtracted. The default weights are:
  - tap 0: (x>>>2)+(x>>>3)
  - tap 1: (x>>>1)+(x>>>3)
  - tap 2: (x>>>1)-(x>>>4)
  - tap 3: -(x>>>2)
- R5: `out_y` is DW+3 bits wide and never overflows, including when the history holds only the extreme codes -2^(DW-1) and 2^(DW-1)-1.
- R6: `out_valid` rises exactly `1+PIPE` cycles after each accepted sample, with one pulse per sample. `out_y` changes in that same cycle.
- R7: A synchronous active-high reset clears the delay line, the pipeline stage, `out_y` and `out_valid` to zero.
- R8: Samples presented on every consecutive cycle are all accepted. Each produces its own result on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample strobe |
| in_data | input | DW | Signed input sample |
| out_valid | output | 1 | Result strobe |
| out_y | output | DW+3 | Signed filter result |

## Verification
The hard case is a new sample arriving in the same cycle that the pipeline stage still carries the previous one. The delay line shifts while the adder tree finishes the earlier sum, so a stale tap or a misaligned stage would corrupt one of the two results. The bench provokes this with back-to-back valid runs, with valid gaps between runs, and with a reset issued while results are still in flight. A behavioural model of the history and pipeline predicts `out_valid` and `out_y`, and both are compared on every cycle.

// File: rtl/fir_pkg.sv
package fir_pkg;
    localparam int NTAP  = 4;
    localparam int NTERM = 3;
    localparam int GUARD = 3;
    localparam int SHW   = 4;

    typedef struct packed {
        logic            en;
        logic            neg;
        logic [SHW-1:0]  sh;
    } term_cfg_t;

    // Index of tap t, term j = t*NTERM + j (MSB side holds tap 3).
    localparam logic [NTAP*NTERM*SHW-1:0] DEF_SH =
        {4'd0, 4'd0, 4'd2,  4'd0, 4'd4, 4'd1,  4'd0, 4'd3, 4'd1,  4'd0, 4'd3, 4'd2};
    localparam logic [NTAP*NTERM-1:0] DEF_EN  = 12'b001_011_011_011;
    localparam logic [NTAP*NTERM-1:0] DEF_NEG = 12'b001_010_000_000;

    function automatic term_cfg_t make_cfg(input logic en, input logic neg,
                                           input logic [SHW-1:0] sh);
        term_cfg_t c;
        c.en  = en;
        c.neg = neg;
        c.sh  = sh;
        return c;
    endfunction
endpackage

// File: rtl/fir_delay_line.sv
module fir_delay_line #(
    parameter int DW    = 16,
    parameter int DEPTH = 3
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       in_valid,
    input  logic [DW-1:0]              in_data,
    output logic [DEPTH-1:0][DW-1:0]   taps
);
    always_ff @(posedge clk) begin
        if (rst) begin
            taps <= '0;
        end else if (in_valid) begin
            taps[0] <= in_data;
            for (int k = 1; k < DEPTH; k++) taps[k] <= taps[k-1];
        end
    end

    p_shift_r2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (taps[0] == $past(in_data)) && (taps[DEPTH-1] == $past(taps[DEPTH-2])));
    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(taps));
endmodule

// File: rtl/fir_tap_weight.sv
module fir_tap_weight
    import fir_pkg::*;
#(
    parameter int                         SW    = 19,
    parameter logic [NTERM*SHW-1:0]       SH    = '0,
    parameter logic [NTERM-1:0]           EN    = '0,
    parameter logic [NTERM-1:0]           NEG   = '0
) (
    input  logic signed [SW-1:0] x_ext,
    output logic signed [SW-1:0] w
);
    logic signed [NTERM-1:0][SW-1:0] term;

    for (genvar j = 0; j < NTERM; j++) begin : g_term
        localparam term_cfg_t CFG = make_cfg(EN[j], NEG[j], SH[j*SHW +: SHW]);
        logic signed [SW-1:0] shifted;
        assign shifted = x_ext >>> CFG.sh;
        if (!CFG.en) begin : g_off
            assign term[j] = '0;
        end else if (CFG.neg) begin : g_sub
            assign term[j] = -shifted;
        end else begin : g_add
            assign term[j] = shifted;
        end
    end

    always_comb begin
        w = '0;
        for (int j = 0; j < NTERM; j++) w = w + $signed(term[j]);
    end
endmodule

// File: rtl/fir_sum_tree.sv
module fir_sum_tree #(
    parameter int SW   = 19,
    parameter int NTAP = 4,
    parameter int PIPE = 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic [NTAP-1:0][SW-1:0]  w,
    output logic                     out_valid,
    output logic signed [SW-1:0]     out_y
);
    localparam int NPAIR = NTAP / 2;

    logic [NPAIR-1:0][SW-1:0] pair_c, pair_q;
    logic                     pv_q;
    logic signed [SW-1:0]     total;

    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
        assign pair_c[p] = $signed(w[2*p]) + $signed(w[2*p+1]);
    end

    if (PIPE != 0) begin : g_pipe
        always_ff @(posedge clk) begin
            if (rst) begin
                pair_q <= '0;
                pv_q   <= 1'b0;
            end else begin
                pv_q <= in_valid;
                if (in_valid) pair_q <= pair_c;
            end
        end
    end else begin : g_comb
        assign pair_q = pair_c;
        assign pv_q   = in_valid;
    end

    always_comb begin
        total = '0;
        for (int p = 0; p < NPAIR; p++) total = total + $signed(pair_q[p]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_y     <= '0;
        end else begin
            out_valid <= pv_q;
            if (pv_q) out_y <= total;
        end
    end

    // Overflow guard: a 32-bit sum must agree with the narrow one.
    always_ff @(posedge clk) begin
        if (!rst && pv_q) begin
            automatic int wide = 0;
            for (int p = 0; p < NPAIR; p++) wide = wide + int'($signed(pair_q[p]));
            p_no_overflow_r5: assert (wide == int'(total));
        end
    end
endmodule

// File: rtl/fir_shiftadd.sv
module fir_shiftadd
    import fir_pkg::*;
#(
    parameter int                          DW    = 16,
    parameter int                          PIPE  = 1,
    parameter logic [NTAP*NTERM*SHW-1:0]   C_SH  = DEF_SH,
    parameter logic [NTAP*NTERM-1:0]       C_EN  = DEF_EN,
    parameter logic [NTAP*NTERM-1:0]       C_NEG = DEF_NEG
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [DW-1:0]        in_data,
    output logic                 out_valid,
    output logic [DW+GUARD-1:0]  out_y
);
    localparam int SW  = DW + GUARD;
    localparam int LAT = 1 + PIPE;

    logic [NTAP-2:0][DW-1:0] hist;
    logic [NTAP-1:0][DW-1:0] smp;
    logic [NTAP-1:0][SW-1:0] wts;
    logic signed [SW-1:0]    y_s;

    fir_delay_line #(.DW(DW), .DEPTH(NTAP-1)) u_dline (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .taps(hist)
    );

    assign smp[0] = in_data;
    for (genvar t = 1; t < NTAP; t++) begin : g_smp
        assign smp[t] = hist[t-1];
    end

    for (genvar t = 0; t < NTAP; t++) begin : g_tap
        logic signed [SW-1:0] xe;
        logic signed [SW-1:0] wt;
        assign xe = {{GUARD{smp[t][DW-1]}}, smp[t]};
        fir_tap_weight #(
            .SW (SW),
            .SH (C_SH [t*NTERM*SHW +: NTERM*SHW]),
            .EN (C_EN [t*NTERM +: NTERM]),
            .NEG(C_NEG[t*NTERM +: NTERM])
        ) u_w (.x_ext(xe), .w(wt));
        assign wts[t] = wt;
    end

    fir_sum_tree #(.SW(SW), .NTAP(NTAP), .PIPE(PIPE)) u_tree (
        .clk(clk), .rst(rst), .in_valid(in_valid), .w(wts),
        .out_valid(out_valid), .out_y(y_s)
    );

    assign out_y = y_s;

    p_latency_r6: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> ##LAT out_valid);
    p_idle_r3: assert property (@(posedge clk) disable iff (rst)
        !in_valid |-> ##LAT !out_valid);
    p_reset_r7: assert property (@(posedge clk)
        rst |=> (!out_valid && out_y == '0));
endmodule

// File: tb/fir_shiftadd_tb.sv
`timescale 1ns/1ps
module fir_shiftadd_tb;
    localparam int DW = 16;
    localparam int YW = DW + 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic out_valid;
    logic [YW-1:0] out_y;

    int errors = 0;
    int checks = 0;

    fir_shiftadd u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .out_valid(out_valid), .out_y(out_y)
    );

    always #10 clk = ~clk;

    // Behavioural model state
    int hist[$];
    int m_pv = 0, m_py = 0, m_ov = 0, m_oy = 0;
    bit armed = 0;

    function automatic int weight(int t, int x);
        case (t)
            0: return (x >>> 2) + (x >>> 3);
            1: return (x >>> 1) + (x >>> 3);
            2: return (x >>> 1) - (x >>> 4);
            default: return -(x >>> 2);
        endcase
    endfunction

    function automatic int ref_y(int x0);
        int s = weight(0, x0);
        for (int k = 0; k < 3; k++) s += weight(k + 1, hist[k]);
        return s;
    endfunction

    task automatic check(string tag);
        int act_y = int'($signed(out_y));
        checks++;
        if (out_valid !== m_ov[0]) begin
            errors++;
            $display("FAIL %s out_valid actual=%0d expected=%0d", tag, out_valid, m_ov);
        end
        checks++;
        if (act_y != m_oy) begin
            errors++;
            $display("FAIL %s out_y actual=%0d expected=%0d", tag, act_y, m_oy);
        end
    endtask

    task automatic step(bit r, bit v, int d, string tag);
        @(negedge clk);
        if (armed) check(tag);
        armed = 1;
        rst = r; in_valid = v; in_data = d[DW-1:0];
        if (r) begin
            m_pv = 0; m_py = 0; m_ov = 0; m_oy = 0;
            hist = '{0, 0, 0};
        end else begin
            m_ov = m_pv;
            if (m_pv != 0) m_oy = m_py;
            m_pv = v;
            if (v) begin
                m_py = ref_y(int'($signed(d[DW-1:0])));
                hist.push_front(int'($signed(d[DW-1:0])));
                void'(hist.pop_back());
            end
        end
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        hist = '{0, 0, 0};
        step(1, 0, 0, "R7");
        step(1, 0, 0, "R7");
        step(0, 0, 0, "R7 reset state");
        // Impulse: shows each tap weight in turn (R1, R4)
        step(0, 1, 16384, "R1");
        for (int i = 0; i < 5; i++) step(0, 1, 0, "R4 impulse");
        // Gaps with garbage data must not advance history (R3)
        step(0, 1, 5000, "R2");
        step(0, 0, 12345, "R3");
        step(0, 0, -777, "R3");
        step(0, 1, -3000, "R2");
        step(0, 0, 999, "R3");
        step(0, 1, 7, "R2");
        for (int i = 0; i < 3; i++) step(0, 0, 0, "R3 hold");
        // Step response, back to back (R8)
        for (int i = 0; i < 6; i++) step(0, 1, 1000, "R8 step");
        // Extremes (R5)
        for (int i = 0; i < 5; i++) step(0, 1, -32768, "R5 min");
        for (int i = 0; i < 5; i++) step(0, 1, 32767, "R5 max");
        for (int i = 0; i < 6; i++) step(0, 1, (i % 2) ? 32767 : -32768, "R5 alt");
        // Random, with sporadic gaps (R1, R6)
        for (int i = 0; i < 300; i++)
            step(0, ($urandom_range(0, 3) != 0), int'($urandom_range(0, 65535)) - 32768, "R6 random");
        // Reset while results in flight (R7)
        step(0, 1, 20000, "R7");
        step(1, 1, 20000, "R7");
        step(0, 0, 0, "R7 after");
        step(0, 0, 0, "R7 after");
        step(0, 1, 800, "R7 restart");
        for (int i = 0; i < 4; i++) step(0, 0, 0, "R6 drain");
        @(negedge clk);
        check("R6 final");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule